// File: doc/BRIEF.md
# Redundant Column-Stream Product Decoder

This block turns the output of a bit-stream multiplier back into an ordinary binary product. The multiplier does not emit a binary word. For each product column it emits a stream of bits. Every partial product that lands in a column is copied `REPL` times, and a fixed run of `PAD` ones is added to the column. The number of set bits in a column is therefore `REPL` times the column's data sum, plus `PAD`. A bounded number of upset bits in a column leaves the integer part of the ratio unchanged.

The decoder is purely combinational and works in three stages:
- A ones-counter for each column counts the set bits in that column's stream. Each counter is sized for its own column.
- Each count is floor-divided by `REPL`. This removes the padding and absorbs any tolerated flips, leaving the column sum.
- The column sums are shifted by their column weights and added to give a `2*OPW`-bit product.

Only the incoming streams are assumed to be corrupted. The counters and the adder themselves carry no protection.

Top module: `stream_product_decoder`

## Requirements
- R1: The input is split into `2*OPW-1` column fields with column 0 at bit 0. Column k holds n_k = min(k+1, 2*OPW-1-k) partial-product slots of `REPL` bits each, followed by `PAD` bits. Each column field starts where the previous one ends. With the defaults (OPW=8, REPL=8, PAD=4) this gives 572 bits in total. Within a column, the slot for operand bits (i, k-i) is ordered by ascending i and sits below the padding.
- R2: When every slot bit equals the AND of its operand bits and every padding bit is 1, `product` equals a*b.
- R3: Setting up to `REPL-1-PAD` (3 by default) extra bits to 1 in any set of columns leaves `product` equal to a*b.
- R4: Clearing up to `PAD` (4 by default) bits to 0 in any set of columns leaves `product` equal to a*b.
- R5: A column may have both set and cleared bits. Let the net change be the number set minus the number cleared. If the net change lies in [-PAD, REPL-1-PAD], `product` still equals a*b.
- R6: Only the number of ones in a column matters, not where they sit inside the column's field.
- R7: Column k contributes floor(ones_k / REPL). A net change of +`REPL-PAD` raises `product` by 2^k. A net change of -(`PAD`+1) lowers it by 2^k.
- R8: `product` equals the sum over k of floor(ones_k / REPL)·2^k. It never exceeds (2^OPW-1)^2, which is 65025 for the all-ones input.
- R9: The output is a combinational function of `streamIn` alone, and an all-zero input gives `product` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| streamIn | input | 572 (derived from OPW, REPL, PAD) | Packed redundant column streams, laid out as in R1 |
| product | output | 2*OPW (16) | Decoded binary product |

## Verification
The bench builds the decoder with OPW=8, REPL=8 and PAD=4. At this size the operand space is small enough to sweep exhaustively: all 65536 operand pairs are applied, once fault-free and once with random up-flips or down-flips in each column. Further random passes cover three more cases: mixed flips inside the tolerance window, ones scattered to random positions within a column, and one column pushed just past the tolerance edge so that its exact weight shows at the output. The 8-row middle column with its 68-bit stream is the widest counter, and every one of its input counts up to the all-ones case is reached.

// File: rtl/streamdec_pkg.sv
package streamdec_pkg;

  // Number of partial-product slots that fall into column k
  function automatic int colRows(int k, int opw);
    return (k < opw) ? k + 1 : 2 * opw - 1 - k;
  endfunction

  // Stream length of column k (replicated slots plus constant padding)
  function automatic int colBits(int k, int opw, int repl, int pad);
    return colRows(k, opw) * repl + pad;
  endfunction

  // Bit position where column k starts in the packed vector
  function automatic int colOffset(int k, int opw, int repl, int pad);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += colBits(j, opw, repl, pad);
    return acc;
  endfunction

  function automatic int streamWidth(int opw, int repl, int pad);
    return colOffset(2 * opw - 1, opw, repl, pad);
  endfunction

endpackage

// File: rtl/column_counter.sv
module column_counter #(
  parameter int NBITS = 68,
  parameter int CNTW  = 7
) (
  input  logic [NBITS-1:0] bits,
  output logic [CNTW-1:0]  count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < NBITS; i++) count = count + CNTW'(bits[i]);
  end

endmodule

// File: rtl/column_divider.sv
module column_divider #(
  parameter int CNTW = 7,
  parameter int REPL = 8,
  parameter int SUMW = 4
) (
  input  logic [CNTW-1:0] count,
  output logic [SUMW-1:0] colSum
);

  localparam bit POW2 = (REPL & (REPL - 1)) == 0;

  generate
    if (POW2) begin : g_shift
      localparam int SH = $clog2(REPL);
      logic [CNTW-1:0] shifted;
      assign shifted = count >> SH;
      assign colSum  = SUMW'(shifted);
    end else begin : g_div
      int quotient;
      assign quotient = int'(count) / REPL;
      assign colSum   = SUMW'(quotient);
    end
  endgenerate

endmodule

// File: rtl/weighted_adder.sv
module weighted_adder #(
  parameter int NCOL = 15,
  parameter int SUMW = 4,
  parameter int OUTW = 16
) (
  input  logic [NCOL*SUMW-1:0] colSumFlat,
  output logic [OUTW-1:0]      product
);

  always_comb begin
    product = '0;
    for (int k = 0; k < NCOL; k++)
      product = product + (OUTW'(colSumFlat[k*SUMW +: SUMW]) << k);
  end

endmodule

// File: rtl/stream_product_decoder.sv
module stream_product_decoder
  import streamdec_pkg::*;
#(
  parameter int OPW  = 8,
  parameter int REPL = 8,
  parameter int PAD  = 4,
  localparam int TOTAL = streamWidth(OPW, REPL, PAD)
) (
  input  logic [TOTAL-1:0] streamIn,
  output logic [2*OPW-1:0] product
);

  localparam int NCOL = 2 * OPW - 1;
  localparam int SUMW = $clog2(OPW + 1);

  logic [NCOL*SUMW-1:0] colSumFlat;

  generate
    for (genvar k = 0; k < NCOL; k++) begin : g_col
      localparam int OFF = colOffset(k, OPW, REPL, PAD);
      localparam int NB  = colBits(k, OPW, REPL, PAD);
      localparam int CW  = $clog2(NB + 1);
      logic [CW-1:0] onesCount;

      column_counter #(.NBITS(NB), .CNTW(CW)) u_cnt (
        .bits  (streamIn[OFF +: NB]),
        .count (onesCount)
      );

      column_divider #(.CNTW(CW), .REPL(REPL), .SUMW(SUMW)) u_div (
        .count  (onesCount),
        .colSum (colSumFlat[k*SUMW +: SUMW])
      );
    end
  endgenerate

  weighted_adder #(.NCOL(NCOL), .SUMW(SUMW), .OUTW(2*OPW)) u_add (
    .colSumFlat (colSumFlat),
    .product    (product)
  );

endmodule

// File: rtl/stream_product_decoder_chk.sv
module stream_product_decoder_chk
  import streamdec_pkg::*;
#(
  parameter int OPW  = 8,
  parameter int REPL = 8,
  parameter int PAD  = 4,
  localparam int TOTAL = streamWidth(OPW, REPL, PAD),
  localparam int NCOL  = 2 * OPW - 1,
  localparam int SUMW  = $clog2(OPW + 1)
) (
  input logic [TOTAL-1:0]     streamIn,
  input logic [NCOL*SUMW-1:0] colSumFlat,
  input logic [2*OPW-1:0]     product
);

  always_comb begin
    longint wide;
    wide = 0;
    for (int k = 0; k < NCOL; k++) begin
      int ones;
      int off;
      int got;
      ones = 0;
      off  = colOffset(k, OPW, REPL, PAD);
      for (int i = 0; i < colBits(k, OPW, REPL, PAD); i++)
        ones += int'(streamIn[off + i]);
      got = int'(colSumFlat[k*SUMW +: SUMW]);
      // R7: each column value is the floor of its ones count over REPL
      assert_floor_decode_R7: assert (got == ones / REPL);
      // R8: a column can never report more than its slot count
      assert_col_bound_R8: assert (got <= colRows(k, OPW));
      wide += longint'(got) << k;
    end
    // R8: the weighted sum fits the output width
    assert_no_overflow_R8: assert (wide < (longint'(1) << (2 * OPW)));
    // R8: the output equals the weighted sum of the column values
    assert_weighted_sum_R8: assert (longint'(product) == wide);
  end

endmodule

bind stream_product_decoder stream_product_decoder_chk #(
  .OPW(OPW), .REPL(REPL), .PAD(PAD)
) u_chk (
  .streamIn   (streamIn),
  .colSumFlat (colSumFlat),
  .product    (product)
);

// File: tb/stream_product_decoder_tb.sv
module stream_product_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OPW  = 8;
  localparam int REPL = 8;
  localparam int PAD  = 4;
  localparam int NCOL = 2 * OPW - 1;

  function automatic int rowsB(int k);
    return (k < OPW) ? k + 1 : 2 * OPW - 1 - k;
  endfunction

  function automatic int bitsB(int k);
    return rowsB(k) * REPL + PAD;
  endfunction

  function automatic int offsB(int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += bitsB(j);
    return s;
  endfunction

  localparam int TOTAL = offsB(NCOL);

  logic clk = 1'b0;
  logic [TOTAL-1:0] stim;
  logic [2*OPW-1:0] prod;
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_product_decoder #(.OPW(OPW), .REPL(REPL), .PAD(PAD)) u_dut (
    .streamIn (stim),
    .product  (prod)
  );

  function automatic int colData(int a, int b, int k);
    int s;
    s = 0;
    for (int i = 0; i < OPW; i++)
      if (k - i >= 0 && k - i < OPW) s += ((a >> i) & (b >> (k - i)) & 1);
    return s;
  endfunction

  task automatic check(int exp, string tag);
    nChecks++;
    if (int'(prod) != exp) begin
      nFail++;
      $display("FAIL %s: product=%0d expected=%0d", tag, prod, exp);
    end
  endtask

  // Slot-ordered fault-free stream for R1/R2
  task automatic buildSlots(int a, int b);
    stim = '0;
    for (int k = 0; k < NCOL; k++) begin
      int base;
      int t;
      base = offsB(k);
      t = 0;
      for (int i = 0; i < OPW; i++) begin
        if (k - i >= 0 && k - i < OPW) begin
          for (int r = 0; r < REPL; r++)
            stim[base + t*REPL + r] = ((a >> i) & (b >> (k - i)) & 1) != 0;
          t++;
        end
      end
      for (int p = 0; p < PAD; p++) stim[base + rowsB(k)*REPL + p] = 1'b1;
    end
  endtask

  task automatic applyFlips(int k, bit toOne, int n, output int done);
    int nb;
    int base;
    int start;
    nb = bitsB(k);
    base = offsB(k);
    start = $urandom_range(nb - 1, 0);
    done = 0;
    for (int s = 0; s < nb; s++) begin
      int pos;
      pos = base + (start + s) % nb;
      if (done < n && stim[pos] != toOne) begin
        stim[pos] = toOne;
        done++;
      end
    end
  endtask

  task automatic fillCount(int k, int cnt);
    int nb;
    int base;
    nb = bitsB(k);
    base = offsB(k);
    for (int i = 0; i < nb; i++) stim[base + i] = (i < cnt);
    for (int i = nb - 1; i > 0; i--) begin
      int j;
      logic tmp;
      j = $urandom_range(i, 0);
      tmp = stim[base + i];
      stim[base + i] = stim[base + j];
      stim[base + j] = tmp;
    end
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish();
  end

  initial begin
    int done;
    stim = '0;

    // R9: all-zero input decodes to zero
    @(posedge clk);
    stim = '0;
    @(negedge clk);
    check(0, "R9 all-zero input");

    // R8: all-ones input gives the largest possible product
    @(posedge clk);
    stim = '1;
    @(negedge clk);
    check((2**OPW - 1) * (2**OPW - 1), "R8 all-ones input");

    // Exhaustive sweep: fault-free (R1, R2), then random up/down flips (R3, R4)
    for (int a = 0; a < 2**OPW; a++) begin
      for (int b = 0; b < 2**OPW; b++) begin
        @(posedge clk);
        buildSlots(a, b);
        @(negedge clk);
        check(a * b, "R1 R2 fault-free");

        @(posedge clk);
        buildSlots(a, b);
        for (int k = 0; k < NCOL; k++) begin
          int m;
          m = $urandom_range(2, 0);
          if (m == 1) applyFlips(k, 1'b1, $urandom_range(REPL - 1 - PAD, 1), done);
          else if (m == 2) applyFlips(k, 1'b0, $urandom_range(PAD, 1), done);
        end
        @(negedge clk);
        check(a * b, "R3 R4 random flips");
      end
    end

    // R5: mixed up and down flips with net change inside the window
    for (int n = 0; n < 2000; n++) begin
      int a;
      int b;
      a = $urandom_range(2**OPW - 1, 0);
      b = $urandom_range(2**OPW - 1, 0);
      @(posedge clk);
      buildSlots(a, b);
      for (int k = 0; k < NCOL; k++) begin
        int u;
        int dLo;
        applyFlips(k, 1'b1, $urandom_range(PAD, 0), u);
        dLo = (u > REPL - 1 - PAD) ? u - (REPL - 1 - PAD) : 0;
        applyFlips(k, 1'b0, $urandom_range(u + PAD, dLo), done);
      end
      @(negedge clk);
      check(a * b, "R5 mixed flips");
    end

    // R6: ones scattered at random positions, net change within tolerance
    for (int n = 0; n < 2000; n++) begin
      int a;
      int b;
      a = $urandom_range(2**OPW - 1, 0);
      b = $urandom_range(2**OPW - 1, 0);
      @(posedge clk);
      for (int k = 0; k < NCOL; k++) begin
        int net;
        net = $urandom_range(REPL - 1, 0) - PAD;
        fillCount(k, REPL * colData(a, b, k) + PAD + net);
      end
      @(negedge clk);
      check(a * b, "R6 scattered ones");
    end

    // R7: one column pushed just outside the tolerance window
    for (int n = 0; n < 2000; n++) begin
      int a;
      int b;
      int kx;
      int s;
      int exp;
      a = $urandom_range(2**OPW - 1, 0);
      b = $urandom_range(2**OPW - 1, 0);
      kx = $urandom_range(NCOL - 1, 0);
      @(posedge clk);
      for (int k = 0; k < NCOL; k++) fillCount(k, REPL * colData(a, b, k) + PAD);
      s = colData(a, b, kx);
      if (s < rowsB(kx)) begin
        fillCount(kx, REPL * s + REPL);
        exp = a * b + (1 << kx);
      end else begin
        fillCount(kx, REPL * s + PAD - (PAD + 1));
        exp = a * b - (1 << kx);
      end
      @(negedge clk);
      check(exp, "R7 column past tolerance");
    end

    finish();
  end

endmodule